// File: doc/BRIEF.md
# Transport Block Code Block Span Counter

This block works out how many code blocks of a transport block are covered by a given input length. A job starts at a code block index and may run up to a total block count. The block keeps a signed running length. For each block in turn, it takes away that block's consumption and counts the block. The loop stops when the running length is no longer positive or the index reaches the total. The block then reports the count with a one-cycle done pulse.

Four modes set how much each block consumes:

- **Turbo encode:** the block's length in bytes after the CRC bits are removed.
- **Turbo decode:** three times the block size plus four, rounded up to a multiple of 32.
- **LDPC decode:** one of two rate-matched output sizes.
- **LDPC encode:** the information length taken from the base graph, the lifting size and the filler count, converted to bytes after the CRC bits are removed.

In the modes that choose between a small and a large size, a split index decides which size each block uses. The block configuration is captured when a job is accepted, so the inputs may change while the job runs.

Top module: `cb_span_counter`

## Requirements
- R1: After reset, `busy`, `done` and `cb_count` are all 0.
- R2: The loop counts one block per cycle while the remaining length is greater than zero and the index is below `blk_total`. The loop stops when the remaining length reaches exactly zero. The loop stops when the index reaches `blk_total`, and the count is then `blk_total - idx_start`.
- R3: When `mode` = 2'b00 (turbo encode), the block size k is `size_a` when the index is below `blk_split`, otherwise `size_b`. Each block consumes (k - c) >> 3, where c is 24 when `crc_en` = 1 and 0 otherwise.
- R4: When `mode` = 2'b01 (turbo decode), the block size k is chosen in the same way as in R3. Each block consumes 3 * roundup32(k + 4).
- R5: When `mode` = 2'b10 (LDPC decode), each block consumes `size_a` when the index is below `blk_split`, otherwise `size_b`.
- R6: When `mode` = 2'b11 (LDPC encode), k = (10 when `bg2` = 1, else 22) * `lift_zc` - `n_fill`. Each block consumes (k - c) >> 3, with c as in R3. `blk_split` has no effect in this mode.
- R7: If `idx_start` >= `blk_total`, or `in_len` <= 0, then `done` rises in the cycle after `start` and `cb_count` is 0.
- R8: Otherwise, `busy` is high from the cycle after `start` until `done`. `done` rises `cb_count` + 2 cycles after the cycle in which `start` is sampled, and `busy` is low when `done` is high.
- R9: `done` lasts one cycle. `cb_count` then holds its value until the next accepted `start`.
- R10: A `start` that arrives while `busy` is high is ignored, and so are changes to the configuration inputs during a job. The running job reports its own result.
- R11: The remaining length is a signed value of `LEN_W` bits. A consumption larger than the remaining length takes it negative and ends the loop; it does not wrap round to a positive value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts a job when the block is idle |
| mode | input | 2 | Consumption rule: 00 turbo encode, 01 turbo decode, 10 LDPC decode, 11 LDPC encode |
| crc_en | input | 1 | Removes 24 CRC bits in the byte-length modes |
| bg2 | input | 1 | Selects base graph 2 in LDPC encode |
| lift_zc | input | ZC_W | Lifting size |
| n_fill | input | NF_W | Filler bit count |
| in_len | input | LEN_W | Signed input length |
| idx_start | input | IDX_W | First code block index |
| blk_total | input | IDX_W | Total number of code blocks |
| blk_split | input | IDX_W | Blocks below this index use `size_a` |
| size_a | input | SZ_W | Small block size, or first rate-matched size |
| size_b | input | SZ_W | Large block size, or second rate-matched size |
| busy | output | 1 | A job is iterating |
| done | output | 1 | One-cycle pulse when the count is final |
| cb_count | output | CNT_W | Number of blocks counted |

## Verification
The bench uses the default parameters: an 8-bit index, a 32-bit signed length, 24-bit sizes and a 16-bit count. The 24-bit sizes make a single consumption near 2^24 possible against a length of 1, which drives the remaining length deeply negative. A design that wrapped the remaining length would go on counting there. The 8-bit index keeps the jobs short enough to cover every mode, both sides of the split index, an exact-zero finish, the case where the total count runs out, and starts that are already finished. The bench also measures the cycle on which `done` arrives and the one-cycle width of the pulse.

// File: rtl/cbc_pkg.sv
package cbc_pkg;

  typedef enum logic [1:0] {
    CBC_TENC = 2'b00,
    CBC_TDEC = 2'b01,
    CBC_LDEC = 2'b10,
    CBC_LENC = 2'b11
  } cbc_mode_e;

  localparam logic [31:0] CBC_CRC_BITS = 32'd24;

  // Bytes of payload carried by a block of k bits after optional CRC removal.
  function automatic logic [31:0] payload_bytes(input logic [31:0] k, input logic crc);
    logic [31:0] trimmed;
    trimmed = k - (crc ? CBC_CRC_BITS : 32'd0);
    return trimmed >> 3;
  endfunction

  // Three streams of (k + 4) bits, each padded to a 32-bit boundary.
  function automatic logic [31:0] triple_padded(input logic [31:0] k);
    logic [31:0] padded;
    padded = (k + 32'd35) & ~32'h1F;
    return padded * 32'd3;
  endfunction

  // Information bits of an LDPC block from its base graph and lifting size.
  function automatic logic [31:0] ldpc_info_bits(input logic g2, input logic [31:0] zc,
                                                 input logic [31:0] nf);
    logic [31:0] cols;
    cols = g2 ? 32'd10 : 32'd22;
    return cols * zc - nf;
  endfunction

endpackage

// File: rtl/cbc_size_sel.sv
module cbc_size_sel
  import cbc_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int SZ_W  = 24,
  parameter int ZC_W  = 9,
  parameter int NF_W  = 11,
  parameter int LEN_W = 32
) (
  input  logic [1:0]       mode,
  input  logic             crc_en,
  input  logic             bg2,
  input  logic [ZC_W-1:0]  lift_zc,
  input  logic [NF_W-1:0]  n_fill,
  input  logic [IDX_W-1:0] idx,
  input  logic [IDX_W-1:0] split,
  input  logic [SZ_W-1:0]  size_a,
  input  logic [SZ_W-1:0]  size_b,
  output logic             pick_a,
  output logic [LEN_W-1:0] cons
);

  logic [31:0] k_sel;
  logic [31:0] raw;

  assign pick_a = (idx < split);

  always_comb begin
    k_sel = pick_a ? 32'(size_a) : 32'(size_b);
    unique case (cbc_mode_e'(mode))
      CBC_TENC: raw = payload_bytes(k_sel, crc_en);
      CBC_TDEC: raw = triple_padded(k_sel);
      CBC_LDEC: raw = k_sel;
      CBC_LENC: raw = payload_bytes(ldpc_info_bits(bg2, 32'(lift_zc), 32'(n_fill)), crc_en);
      default:  raw = 32'd0;
    endcase
    cons = LEN_W'(raw);
  end

endmodule

// File: rtl/cbc_loop_ctrl.sv
module cbc_loop_ctrl #(
  parameter int IDX_W = 8,
  parameter int LEN_W = 32,
  parameter int CNT_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic signed [LEN_W-1:0] in_len,
  input  logic [IDX_W-1:0]        idx_start,
  input  logic [IDX_W-1:0]        blk_total,
  input  logic [LEN_W-1:0]        cons,
  output logic [IDX_W-1:0]        idx_q,
  output logic [IDX_W-1:0]        total_q,
  output logic                    busy,
  output logic                    done,
  output logic                    step_fire,
  output logic [CNT_W-1:0]        count
);

  logic signed [LEN_W-1:0] rem_q;
  logic                    busy_q;
  logic                    done_q;
  logic [CNT_W-1:0]        cnt_q;
  logic                    accept;
  logic                    live;
  logic                    finish;
  logic                    init_ok;

  assign accept    = start && !busy_q;
  assign init_ok   = (in_len > 0) && (idx_start < blk_total);
  assign live      = busy_q && (rem_q > 0) && (idx_q < total_q);
  assign finish    = busy_q && !live;
  assign step_fire = live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q   <= '0;
      idx_q   <= '0;
      total_q <= '0;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        rem_q   <= in_len;
        idx_q   <= idx_start;
        total_q <= blk_total;
        cnt_q   <= '0;
        if (init_ok) busy_q <= 1'b1;
        else         done_q <= 1'b1;
      end else if (live) begin
        rem_q <= rem_q - $signed(cons);
        idx_q <= idx_q + 1'b1;
        cnt_q <= cnt_q + 1'b1;
      end else if (finish) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  assign busy  = busy_q;
  assign done  = done_q;
  assign count = cnt_q;

endmodule

// File: rtl/cb_span_counter.sv
module cb_span_counter #(
  parameter int IDX_W = 8,
  parameter int LEN_W = 32,
  parameter int SZ_W  = 24,
  parameter int ZC_W  = 9,
  parameter int NF_W  = 11,
  parameter int CNT_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [1:0]              mode,
  input  logic                    crc_en,
  input  logic                    bg2,
  input  logic [ZC_W-1:0]         lift_zc,
  input  logic [NF_W-1:0]         n_fill,
  input  logic signed [LEN_W-1:0] in_len,
  input  logic [IDX_W-1:0]        idx_start,
  input  logic [IDX_W-1:0]        blk_total,
  input  logic [IDX_W-1:0]        blk_split,
  input  logic [SZ_W-1:0]         size_a,
  input  logic [SZ_W-1:0]         size_b,
  output logic                    busy,
  output logic                    done,
  output logic [CNT_W-1:0]        cb_count
);

  logic [1:0]       mode_q;
  logic             crc_q;
  logic             bg2_q;
  logic [ZC_W-1:0]  zc_q;
  logic [NF_W-1:0]  nf_q;
  logic [IDX_W-1:0] split_q;
  logic [SZ_W-1:0]  a_q;
  logic [SZ_W-1:0]  b_q;

  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] total_q;
  logic [LEN_W-1:0] cons;
  logic             pick_a;
  logic             step_fire;
  logic             cfg_load;

  assign cfg_load = start && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      crc_q   <= 1'b0;
      bg2_q   <= 1'b0;
      zc_q    <= '0;
      nf_q    <= '0;
      split_q <= '0;
      a_q     <= '0;
      b_q     <= '0;
    end else if (cfg_load) begin
      mode_q  <= mode;
      crc_q   <= crc_en;
      bg2_q   <= bg2;
      zc_q    <= lift_zc;
      nf_q    <= n_fill;
      split_q <= blk_split;
      a_q     <= size_a;
      b_q     <= size_b;
    end
  end

  cbc_size_sel #(
    .IDX_W(IDX_W), .SZ_W(SZ_W), .ZC_W(ZC_W), .NF_W(NF_W), .LEN_W(LEN_W)
  ) u_size (
    .mode   (mode_q),
    .crc_en (crc_q),
    .bg2    (bg2_q),
    .lift_zc(zc_q),
    .n_fill (nf_q),
    .idx    (idx_q),
    .split  (split_q),
    .size_a (a_q),
    .size_b (b_q),
    .pick_a (pick_a),
    .cons   (cons)
  );

  cbc_loop_ctrl #(
    .IDX_W(IDX_W), .LEN_W(LEN_W), .CNT_W(CNT_W)
  ) u_loop (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .in_len   (in_len),
    .idx_start(idx_start),
    .blk_total(blk_total),
    .cons     (cons),
    .idx_q    (idx_q),
    .total_q  (total_q),
    .busy     (busy),
    .done     (done),
    .step_fire(step_fire),
    .count    (cb_count)
  );

endmodule

// File: rtl/cbc_checker.sv
module cbc_checker #(
  parameter int IDX_W = 8,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic [CNT_W-1:0] cb_count,
  input logic             step_fire,
  input logic [IDX_W-1:0] idx_q,
  input logic [IDX_W-1:0] total_q
);

  AST_STEP_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
    step_fire |=> cb_count == $past(cb_count) + 1'b1); // R2

  AST_IDX_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> idx_q <= total_q); // R2

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R8

  AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done); // R8

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> !done); // R9

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start |=> $stable(cb_count)); // R9

  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> $stable(total_q)); // R10

endmodule

bind cb_span_counter cbc_checker #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .cb_count (cb_count),
  .step_fire(step_fire),
  .idx_q    (idx_q),
  .total_q  (total_q)
);

// File: tb/cb_span_counter_bench.sv
module cb_span_counter_bench;

  localparam int CLK_PERIOD = 10;
  localparam int IDX_W = 8, LEN_W = 32, SZ_W = 24, ZC_W = 9, NF_W = 11, CNT_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] mode = '0;
  logic crc_en = 1'b0, bg2 = 1'b0;
  logic [ZC_W-1:0] lift_zc = '0;
  logic [NF_W-1:0] n_fill = '0;
  logic signed [LEN_W-1:0] in_len = '0;
  logic [IDX_W-1:0] idx_start = '0, blk_total = '0, blk_split = '0;
  logic [SZ_W-1:0] size_a = '0, size_b = '0;
  logic busy, done;
  logic [CNT_W-1:0] cb_count;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cb_span_counter #(
    .IDX_W(IDX_W), .LEN_W(LEN_W), .SZ_W(SZ_W), .ZC_W(ZC_W), .NF_W(NF_W), .CNT_W(CNT_W)
  ) u_cb_span_counter (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .crc_en(crc_en), .bg2(bg2),
    .lift_zc(lift_zc), .n_fill(n_fill), .in_len(in_len), .idx_start(idx_start),
    .blk_total(blk_total), .blk_split(blk_split), .size_a(size_a), .size_b(size_b),
    .busy(busy), .done(done), .cb_count(cb_count)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Independent reference: integer walk over the blocks.
  function automatic int model(input int md, input longint len, input int r0, input int c,
                               input int split, input longint a, input longint b,
                               input bit crc, input bit g2, input int zc, input int nf);
    longint rem = len;
    int n = 0;
    for (int r = r0; r < c && rem > 0; r++) begin
      longint k = (r < split) ? a : b;
      longint use_len;
      case (md)
        0: use_len = (k - (crc ? 24 : 0)) / 8;
        1: use_len = 3 * (((k + 4 + 31) / 32) * 32);
        2: use_len = k;
        default: use_len = (((g2 ? 10 : 22) * zc) - nf - (crc ? 24 : 0)) / 8;
      endcase
      rem = rem - use_len;
      n++;
    end
    return n;
  endfunction

  task automatic drive(input int md, input longint len, input int r0, input int c,
                       input int split, input longint a, input longint b,
                       input bit crc, input bit g2, input int zc, input int nf);
    mode = md[1:0]; in_len = len[LEN_W-1:0]; idx_start = r0[IDX_W-1:0];
    blk_total = c[IDX_W-1:0]; blk_split = split[IDX_W-1:0];
    size_a = a[SZ_W-1:0]; size_b = b[SZ_W-1:0]; crc_en = crc; bg2 = g2;
    lift_zc = zc[ZC_W-1:0]; n_fill = nf[NF_W-1:0];
  endtask

  task automatic wait_done(output int lat);
    lat = 1;
    while (!done && lat < 1000) begin
      @(posedge clk); @(negedge clk);
      lat++;
    end
  endtask

  task automatic run_job(input string req, input int md, input longint len, input int r0,
                         input int c, input int split, input longint a, input longint b,
                         input bit crc, input bit g2, input int zc, input int nf,
                         input int exp_hand);
    int expv;
    int lat;
    int exp_lat;
    expv = model(md, len, r0, c, split, a, b, crc, g2, zc, nf);
    exp_lat = (expv == 0) ? 1 : expv + 2;
    drive(md, len, r0, c, split, a, b, crc, g2, zc, nf);
    start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    wait_done(lat);
    chk(expv == exp_hand, {req, " model"}, expv, exp_hand);
    chk(cb_count == CNT_W'(expv), req, cb_count, expv);
    chk(lat == exp_lat, "R8 latency", lat, exp_lat);
    chk(!busy, "R8 busy low at done", busy, 0);
    @(posedge clk); @(negedge clk);
    chk(!done, "R9 pulse width", done, 0);
    @(posedge clk); @(negedge clk);
    chk(cb_count == CNT_W'(expv), "R9 hold", cb_count, expv);
  endtask

  task automatic t_reset;
    chk(!busy, "R1 busy", busy, 0);
    chk(!done, "R1 done", done, 0);
    chk(cb_count == 0, "R1 count", cb_count, 0);
  endtask

  task automatic t_turbo_enc;
    run_job("R3 crc split", 0, 1000, 0, 4, 1, 40, 6144, 1, 0, 0, 0, 3);
    run_job("R3 nocrc start mid", 0, 1600, 1, 4, 1, 40, 6144, 0, 0, 0, 0, 3);
  endtask

  task automatic t_turbo_dec;
    run_job("R4 split", 1, 4000, 0, 5, 2, 40, 1024, 0, 0, 0, 0, 4);
  endtask

  task automatic t_ldpc_dec;
    run_job("R5 R2 exact zero", 2, 3400, 1, 6, 2, 1000, 1200, 0, 0, 0, 0, 3);
  endtask

  task automatic t_ldpc_enc;
    run_job("R6 R2 total reached", 3, 100000, 0, 3, 0, 0, 0, 1, 0, 384, 0, 3);
    run_job("R6 bg2 filler", 3, 200, 0, 10, 5, 7, 9, 0, 1, 52, 8, 4);
  endtask

  task automatic t_degenerate;
    run_job("R7 index at total", 2, 100, 5, 5, 0, 10, 10, 0, 0, 0, 0, 0);
    run_job("R7 zero length", 2, 0, 0, 5, 0, 10, 10, 0, 0, 0, 0, 0);
    run_job("R7 negative length", 1, -7, 0, 5, 0, 10, 10, 0, 0, 0, 0, 0);
  endtask

  task automatic t_no_wrap;
    run_job("R11 deep negative", 2, 1, 0, 2, 2, 24'hFFFFFF, 24'hFFFFFF, 0, 0, 0, 0, 1);
  endtask

  task automatic t_busy_start;
    int expv;
    int lat;
    expv = model(1, 4000, 0, 5, 2, 40, 1024, 0, 0, 0, 0);
    drive(1, 4000, 0, 5, 2, 40, 1024, 0, 0, 0, 0);
    start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    @(posedge clk); @(negedge clk);
    drive(2, 1, 0, 9, 0, 1, 1, 0, 0, 0, 0);
    start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    wait_done(lat);
    lat = lat + 2;
    chk(cb_count == CNT_W'(expv), "R10 result of running job", cb_count, expv);
    chk(lat == expv + 2, "R10 latency unchanged", lat, expv + 2);
    @(posedge clk); @(negedge clk);
    chk(!done && !busy, "R10 no second job", {busy, done}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_turbo_enc;
    t_turbo_dec;
    t_ldpc_dec;
    t_ldpc_enc;
    t_degenerate;
    t_no_wrap;
    t_busy_start;
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

endmodule